// File: doc/BRIEF.md
# Audio Sample Clock Ratio Detector and Divider

This block sits in the master-clock domain of an audio converter. It either produces the serial bit clock and frame clock itself, or it follows an external frame clock. With the strap set to master, a free-running counter divides the master clock by 4 to make the bit clock, which gives 64 bit-clock periods per frame. The same counter divides by 256 to make the frame clock. It also produces a sampling strobe on every second master cycle.

With the strap set to slave, the external frame clock is brought into the master-clock domain. The block counts master cycles from one rising frame edge to the next and sorts the count into one of three supported ratios: 256, 384 or 512 master cycles per frame. A count is accepted within a tolerance window, and the same class must be seen for two periods in a row before the ratio is reported valid. Once the ratio is valid, a divider of 2, 3 or 4 is selected. The divider restarts on every frame edge and gives exactly 128 sampling strobes per frame.

If the frame clock stops, the ratio is dropped. A new ratio is detected when the frame clock returns.

Top module: `audio_clk_ratio`

## Requirements
- R1: In master mode, after the k-th rising master-clock edge since reset release, `sclk_out` equals bit 1 of k. This divides the master clock by 4.
- R2: In master mode `lrck_out` equals bit 7 of that same count k, which divides the master clock by 256. It changes only on a falling edge of `sclk_out`.
- R3: In master mode `sample_stb` is high exactly when k is odd. `ratio_code` reads 2'b00 and `ratio_ok` reads 1.
- R4: In slave mode, a frame period of P master cycles, measured between rising edges of `lrck_in`, is classed as follows: code 2'b00 when |P-256| <= 2, code 2'b01 when |P-384| <= 2, code 2'b10 when |P-512| <= 2.
- R5: A slave-mode period outside all three windows gives `ratio_ok` = 0 and `ratio_code` = 2'b11.
- R6: `ratio_ok` rises only when two consecutive periods fall in the same window. After reset it is 0 after two rising frame edges and 1 after the third. It changes only in the cycle after a detected frame edge.
- R7: A change of ratio while valid drops `ratio_ok` (code 2'b11) at the first differing period. The new code becomes valid once two consecutive periods match it.
- R8: In slave mode with a valid ratio of exactly 256, 384 or 512, `sample_stb` pulses 128 times per frame. While `ratio_ok` is 0 it stays low.
- R9: In slave mode, if no rising frame edge arrives for more than 514 master cycles, `ratio_ok` clears and `ratio_code` reads 2'b11. Detection restarts when edges resume.
- R10: In slave mode `sclk_out` and `lrck_out` are held low.
- R11: During reset in slave mode, `ratio_ok` = 0, `ratio_code` = 2'b11 and `sample_stb` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| mclk | input | 1 | Master clock; the only clock domain |
| rst_n | input | 1 | Active-low synchronous reset |
| master_mode | input | 1 | Strap: 1 = generate clocks, 0 = follow `lrck_in` |
| lrck_in | input | 1 | External frame clock used in slave mode |
| sclk_out | output | 1 | Generated bit clock (master mode) |
| lrck_out | output | 1 | Generated frame clock (master mode) |
| sample_stb | output | 1 | One-cycle strobe at 128 times the frame rate |
| ratio_code | output | 2 | 00 = 256, 01 = 384, 10 = 512, 11 = invalid |
| ratio_ok | output | 1 | Ratio is valid and the strobe divider is running |

## Verification
In master mode the outputs are decoded straight from the cycle count, so every cycle after reset release is compared against the bits of that count. In slave mode a frame edge passes through two synchronizer stages and an edge detector, and the ratio flags register one cycle later. That is a delay of about four master cycles after a rise of `lrck_in`. The bench therefore reads the ratio flags only at the end of a frame, at least 100 cycles after the last rise. Strobes are counted over a full window of one frame period. With an exact ratio the strobe pattern repeats every frame, so the count is 128 whatever the window phase.

// File: rtl/audio_clk_ratio.sv
module audio_clk_ratio #(
  parameter int BASE     = 256,
  parameter int OSR      = 128,
  parameter int SCLK_DIV = 4,
  parameter int TOL      = 2
) (
  input  logic       mclk,
  input  logic       rst_n,
  input  logic       master_mode,
  input  logic       lrck_in,
  output logic       sclk_out,
  output logic       lrck_out,
  output logic       sample_stb,
  output logic [1:0] ratio_code,
  output logic       ratio_ok
);
  localparam int R0    = BASE;
  localparam int R1    = BASE * 3 / 2;
  localparam int R2    = BASE * 2;
  localparam int LIMIT = R2 + TOL;
  localparam int CW    = $clog2(LIMIT + 2);
  localparam int MW    = $clog2(BASE);
  localparam int SB    = $clog2(SCLK_DIV) - 1;
  localparam int MSTB  = $clog2(BASE / OSR);
  localparam int DW    = $clog2(R2 / OSR) + 1;
  localparam logic [1:0] INV = 2'b11;
  localparam logic [DW-1:0] D0 = DW'(R0 / OSR);
  localparam logic [DW-1:0] D1 = DW'(R1 / OSR);
  localparam logic [DW-1:0] D2 = DW'(R2 / OSR);

  // master-mode generator
  logic [MW-1:0] mdiv;
  always_ff @(posedge mclk) begin
    if (!rst_n || !master_mode) mdiv <= '0;
    else                        mdiv <= mdiv + 1'b1;
  end

  assign sclk_out = master_mode & mdiv[SB];
  assign lrck_out = master_mode & mdiv[MW-1];

  // slave-mode frame edge capture
  logic [2:0] lr_sync;
  logic       edge_seen;
  always_ff @(posedge mclk) begin
    if (!rst_n) lr_sync <= '0;
    else        lr_sync <= {lr_sync[1:0], lrck_in};
  end
  assign edge_seen = ~master_mode & lr_sync[1] & ~lr_sync[2];

  logic [CW-1:0] pcnt;
  always_ff @(posedge mclk) begin
    if (!rst_n || master_mode)    pcnt <= '0;
    else if (edge_seen)           pcnt <= '0;
    else if (pcnt != CW'(LIMIT))  pcnt <= pcnt + 1'b1;
  end

  function automatic logic [1:0] classify(input int m);
    if (m >= R0 - TOL && m <= R0 + TOL) return 2'b00;
    if (m >= R1 - TOL && m <= R1 + TOL) return 2'b01;
    if (m >= R2 - TOL && m <= R2 + TOL) return 2'b10;
    return INV;
  endfunction

  int         meas;
  logic [1:0] cls;
  assign meas = int'(pcnt) + 1;
  assign cls  = classify(meas);

  logic       armed, slave_ok;
  logic [1:0] last_cls, held_cls;
  always_ff @(posedge mclk) begin
    if (!rst_n || master_mode) begin
      armed    <= 1'b0;
      slave_ok <= 1'b0;
      last_cls <= INV;
      held_cls <= INV;
    end else if (edge_seen) begin
      armed <= 1'b1;
      if (armed) begin
        last_cls <= cls;
        if (cls != INV && cls == last_cls) begin
          slave_ok <= 1'b1;
          held_cls <= cls;
        end else begin
          slave_ok <= 1'b0;
        end
      end
    end else if (pcnt == CW'(LIMIT)) begin
      slave_ok <= 1'b0;
      last_cls <= INV;
    end
  end

  // slave-mode sampling strobe divider
  logic [DW-1:0] dv, sdiv;
  always_comb begin
    case (held_cls)
      2'b00:   dv = D0;
      2'b01:   dv = D1;
      default: dv = D2;
    endcase
  end

  always_ff @(posedge mclk) begin
    if (!rst_n || !slave_ok || edge_seen) sdiv <= '0;
    else if (sdiv == dv - 1'b1)           sdiv <= '0;
    else                                  sdiv <= sdiv + 1'b1;
  end

  assign sample_stb = master_mode ? (&mdiv[MSTB-1:0]) : (slave_ok && sdiv == dv - 1'b1);
  assign ratio_code = master_mode ? 2'b00 : (slave_ok ? held_cls : INV);
  assign ratio_ok   = master_mode | slave_ok;

  p_ok_on_edge_r6: assert property (@(posedge mclk) disable iff (!rst_n)
    $rose(slave_ok) |-> $past(edge_seen));

  p_stb_quiet_r8: assert property (@(posedge mclk) disable iff (!rst_n)
    (!master_mode && !slave_ok) |-> !sample_stb);

  p_lrck_on_sclk_fall_r2: assert property (@(posedge mclk) disable iff (!rst_n)
    (master_mode && $past(master_mode) && !$stable(lrck_out)) |-> $fell(sclk_out));

  p_master_stb_alt_r3: assert property (@(posedge mclk) disable iff (!rst_n)
    (master_mode && sample_stb) |=> (!master_mode || !sample_stb));

  p_count_cap_r9: assert property (@(posedge mclk) disable iff (!rst_n)
    int'(pcnt) <= LIMIT);
endmodule

// File: tb/audio_clk_ratio_test.sv
module audio_clk_ratio_test;
  localparam time CLK_PERIOD = 10ns;

  logic       mclk = 1'b0;
  logic       rst_n = 1'b0;
  logic       master_mode = 1'b0;
  logic       lrck_in = 1'b0;
  logic       sclk_out, lrck_out, sample_stb, ratio_ok;
  logic [1:0] ratio_code;

  int checks = 0;
  int fails  = 0;
  int pin_bad = 0;

  audio_clk_ratio uut (
    .mclk(mclk), .rst_n(rst_n), .master_mode(master_mode), .lrck_in(lrck_in),
    .sclk_out(sclk_out), .lrck_out(lrck_out), .sample_stb(sample_stb),
    .ratio_code(ratio_code), .ratio_ok(ratio_ok)
  );

  always #(CLK_PERIOD / 2) mclk = ~mclk;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic do_reset(input bit mm);
    @(negedge mclk);
    rst_n = 1'b0;
    master_mode = mm;
    lrck_in = 1'b0;
    repeat (4) @(negedge mclk);
    rst_n = 1'b1;
  endtask

  task automatic run_period(input int n, output int stbs);
    stbs = 0;
    for (int i = 0; i < n; i++) begin
      lrck_in = (i >= n / 2);
      @(negedge mclk);
      if (sample_stb) stbs++;
      if (sclk_out || lrck_out) pin_bad++;
    end
  endtask

  function automatic int exp_code(input int p);
    if (p >= 254 && p <= 258) return 0;
    if (p >= 382 && p <= 386) return 1;
    if (p >= 510 && p <= 514) return 2;
    return 3;
  endfunction

  task automatic sweep_point(input int p);
    int s, ec;
    ec = exp_code(p);
    do_reset(1'b0);
    run_period(p, s);
    chk(s == 0, "R8 no strobe before valid", s, 0);
    run_period(p, s);
    chk(ratio_ok == 1'b0, "R6 not valid after two edges", ratio_ok, 0);
    run_period(p, s);
    if (ec == 3) begin
      chk(ratio_ok == 1'b0 && ratio_code == 2'b11, "R5 out-of-window period", ratio_code, 3);
    end else begin
      chk(ratio_ok == 1'b1, "R6 valid after third edge", ratio_ok, 1);
      chk(int'(ratio_code) == ec, "R4 ratio class", ratio_code, ec);
      if (p == 256 || p == 384 || p == 512) begin
        run_period(p, s);
        chk(s == 128, "R8 strobes per frame", s, 128);
      end
    end
  endtask

  initial begin
    int s, bad_sclk, bad_lrck, bad_stb, bad_flags;
    // R11 reset state in slave mode
    @(negedge mclk);
    rst_n = 1'b0;
    master_mode = 1'b0;
    repeat (3) @(negedge mclk);
    chk(ratio_ok == 1'b0 && ratio_code == 2'b11 && sample_stb == 1'b0,
        "R11 reset state", {ratio_ok, ratio_code, sample_stb}, 3'b011 << 1);

    // master mode: R1 R2 R3 over two full frames
    do_reset(1'b1);
    bad_sclk = 0; bad_lrck = 0; bad_stb = 0; bad_flags = 0;
    for (int k = 1; k <= 512; k++) begin
      @(negedge mclk);
      if (sclk_out != k[1]) bad_sclk++;
      if (lrck_out != k[7]) bad_lrck++;
      if (sample_stb != k[0]) bad_stb++;
      if (ratio_code != 2'b00 || ratio_ok != 1'b1) bad_flags++;
    end
    chk(bad_sclk == 0, "R1 bit clock divide by 4", bad_sclk, 0);
    chk(bad_lrck == 0, "R2 frame clock divide by 256", bad_lrck, 0);
    chk(bad_stb == 0, "R3 master strobe every other cycle", bad_stb, 0);
    chk(bad_flags == 0, "R3 master ratio flags", bad_flags, 0);

    // slave sweep around each ratio and beyond
    pin_bad = 0;
    for (int off = -3; off <= 3; off++) begin
      sweep_point(256 + off);
      sweep_point(384 + off);
      sweep_point(512 + off);
    end
    sweep_point(200);
    sweep_point(320);
    sweep_point(450);

    // R7 ratio change
    do_reset(1'b0);
    repeat (3) run_period(256, s);
    chk(ratio_ok == 1'b1 && ratio_code == 2'b00, "R7 initial 256 valid", ratio_code, 0);
    run_period(512, s);
    chk(ratio_ok == 1'b0 && ratio_code == 2'b11, "R7 drop on change", ratio_code, 3);
    run_period(512, s);
    run_period(512, s);
    chk(ratio_ok == 1'b1 && ratio_code == 2'b10, "R7 new ratio valid", ratio_code, 2);

    // R9 lost frame clock and recovery
    lrck_in = 1'b0;
    repeat (700) @(negedge mclk);
    chk(ratio_ok == 1'b0 && ratio_code == 2'b11, "R9 lost frame clock", ratio_code, 3);
    run_period(384, s);
    run_period(384, s);
    chk(ratio_ok == 1'b0, "R9 no early recovery", ratio_ok, 0);
    run_period(384, s);
    chk(ratio_ok == 1'b1 && ratio_code == 2'b01, "R9 recovery", ratio_code, 1);

    chk(pin_bad == 0, "R10 clock outputs low in slave", pin_bad, 0);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge mclk);
    checks++;
    fails++;
    $display("FAIL watchdog: actual %0d expected %0d", 200000, 0);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule